// File: doc/BRIEF.md
# Staged-Load Feedback Clock Divider

This block divides a reference clock by a programmable integer N and marks every Nth reference cycle with a one-cycle enable pulse. It is intended for the feedback path of a clock synthesiser. N is 11 bits wide and is programmed over a small byte-wide register bus as two write-only bytes.

The low byte goes into a staging register first and has no effect on the divider by itself. A write to the high byte joins its three used bits with the staged low byte and commits the 11-bit result to the active divider in one step. A committed value of 0 or 1 is replaced by 2. The bus accepts writes only while the external PLL-enable input is low, and every read returns zero.

A new value never cuts short the period that is already running. It applies from the next counter reload onwards.

Top module: `fbdiv_top`

## Requirements
- R1: Synchronous active-high reset sets the staged low byte to 02h, the active N to 2 and the counter to zero. `divPulse` is low during reset, its first pulse comes one cycle after reset is released, and it then repeats every 2 cycles.
- R2: `divPulse` is high for exactly one cycle, and consecutive pulses are exactly N reference cycles apart.
- R3: A write to address 5Ch only loads the staging register. The output period does not change until a high-byte write follows.
- R4: A write to address 5Dh commits N = {wrData[2:0], staged low byte}. Bits [7:3] of that write are ignored.
- R5: A newly committed N takes effect at the next counter reload. The period in progress finishes at the old length.
- R6: A committed value of 0 or 1 makes the divider run with N = 2.
- R7: While `pllEnable` is high, writes to either address change neither the staged low byte nor the active N.
- R8: A read of either address returns 00h on `busRdData` in the cycle after the read strobe.
- R9: Writes to any address other than 5Ch and 5Dh have no effect on the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pllEnable | input | 1 | When high, register writes are locked out |
| busAddr | input | 8 | Register bus address |
| busWrData | input | 8 | Register bus write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, registered, always zero |
| divPulse | output | 1 | One-cycle pulse every N reference cycles |

## Verification
Both bus writes are sampled at the edge where the strobe is high. A high-byte write changes the active N at that edge. The change first shows on `divPulse` at the reload that follows, which is the edge after the counter reaches zero. Read data appears one edge after the read strobe. A behavioural model in the bench applies these same latencies at every rising edge, and its pulse is compared with the design at each falling edge. Period checks measure the spacing between recorded pulse times after enough pulses have passed for any commit to have landed.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int BYTE_W = 8;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic              loadLow;
    logic              commit;
    logic [BYTE_W-1:0] wrByte;
  } fbdivStrobe_t;

  // replaces too-small divide values with the minimum
  function automatic logic [15:0] clampDiv(input logic [15:0] raw, input int minDiv);
    clampDiv = (raw < 16'(minDiv)) ? 16'(minDiv) : raw;
  endfunction
endpackage

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 8'h5C,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pllEnable,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [BYTE_W-1:0] busRdData,
  output fbdivStrobe_t      strb
);
  logic wrOpen;
  logic [BYTE_W-1:0] rdQ;

  // writes pass only while the loop is disabled
  assign wrOpen = busWr && !pllEnable;

  always_comb begin
    strb.loadLow = wrOpen && (busAddr == LOW_ADDR);
    strb.commit  = wrOpen && (busAddr == HIGH_ADDR);
    strb.wrByte  = busWrData;
  end

  // both registers are write-only: read data is zero
  always_ff @(posedge clk) begin
    if (rst)        rdQ <= '0;
    else if (busRd) rdQ <= {BYTE_W{1'b0}};
  end

  assign busRdData = rdQ;
endmodule

// File: rtl/fbdiv_datapath.sv
module fbdiv_datapath
  import fbdiv_pkg::*;
#(
  parameter int DIV_W = 11,
  parameter int MIN_DIV = 2,
  parameter logic [BYTE_W-1:0] RESET_LOW = 8'h02
) (
  input  logic               clk,
  input  logic               rst,
  input  fbdivStrobe_t       strb,
  output logic               divPulse,
  output logic [BYTE_W-1:0]  stageLow,
  output logic [DIV_W-1:0]   activeN,
  output logic [DIV_W-1:0]   cnt
);
  localparam int HIGH_W = DIV_W - BYTE_W;
  localparam logic [DIV_W-1:0] RESET_N =
    DIV_W'(clampDiv(16'(RESET_LOW), MIN_DIV));

  logic [DIV_W-1:0] rawN;
  logic [DIV_W-1:0] safeN;

  assign rawN  = {strb.wrByte[HIGH_W-1:0], stageLow};
  assign safeN = DIV_W'(clampDiv(16'(rawN), MIN_DIV));

  // staging byte
  always_ff @(posedge clk) begin
    if (rst)               stageLow <= RESET_LOW;
    else if (strb.loadLow) stageLow <= strb.wrByte;
  end

  // active value, committed whole on the high-byte write
  always_ff @(posedge clk) begin
    if (rst)              activeN <= RESET_N;
    else if (strb.commit) activeN <= safeN;
  end

  // down-counter, reloads from the active value only at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      divPulse <= 1'b0;
    end else if (cnt == '0) begin
      cnt      <= activeN - 1'b1;
      divPulse <= 1'b1;
    end else begin
      cnt      <= cnt - 1'b1;
      divPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int DIV_W = 11,
  parameter int MIN_DIV = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pllEnable,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdData,
  output logic              divPulse
);
  fbdivStrobe_t      strb;
  logic [BYTE_W-1:0] stageLow;
  logic [DIV_W-1:0]  activeN;
  logic [DIV_W-1:0]  cnt;

  fbdiv_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .pllEnable(pllEnable), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .strb(strb)
  );

  fbdiv_datapath #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .divPulse(divPulse),
    .stageLow(stageLow), .activeN(activeN), .cnt(cnt)
  );
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk #(
  parameter int DIV_W = 11,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pllEnable,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              divPulse,
  input logic [7:0]        stageLow,
  input logic [DIV_W-1:0]  activeN,
  input logic [DIV_W-1:0]  cnt
);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R2
  reload_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> divPulse);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  min_div_chk: assert property (@(posedge clk) disable iff (rst)
    activeN >= DIV_W'(2));

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && pllEnable) |=> ($stable(activeN) && $stable(stageLow)));

  // R3
  low_only_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == 8'h5C) |=> $stable(activeN));
endmodule

bind fbdiv_top fbdiv_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .pllEnable(pllEnable), .busWr(busWr),
  .busAddr(busAddr), .divPulse(divPulse), .stageLow(stageLow),
  .activeN(activeN), .cnt(cnt)
);

// File: tb/fbdiv_top_tb_top.sv
`timescale 1ns/1ps
module fbdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pllEnable = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdData;
  logic       divPulse;

  int vecs = 0;
  int errs = 0;
  int cyc = 0;
  int pulseAt[$];

  // reference model state
  int  mStage = 2;
  int  mActive = 2;
  int  mCnt = 0;
  bit  mPulse = 0;

  always #10 clk = ~clk;

  fbdiv_top dut_i (
    .clk(clk), .rst(rst), .pllEnable(pllEnable), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .divPulse(divPulse)
  );

  always @(posedge clk) begin
    int nextAct;
    int raw;
    if (rst) begin
      mStage = 2; mActive = 2; mCnt = 0; mPulse = 0;
    end else begin
      nextAct = mActive;
      if (busWr && !pllEnable && busAddr == 8'h5D) begin
        raw = (int'(busWrData[2:0]) << 8) + mStage;
        nextAct = (raw < 2) ? 2 : raw;
      end
      if (busWr && !pllEnable && busAddr == 8'h5C) mStage = busWrData;
      if (mCnt == 0) begin mPulse = 1; mCnt = mActive - 1; end
      else begin mPulse = 0; mCnt = mCnt - 1; end
      mActive = nextAct;
    end
  end

  // per-cycle comparison and pulse time log (R2)
  always @(negedge clk) begin
    cyc++;
    vecs++;
    if (divPulse !== mPulse) begin
      errs++;
      $display("FAIL R2 cycle %0d: divPulse=%0b expected=%0b", cyc, divPulse, mPulse);
    end
    if (divPulse) pulseAt.push_back(cyc);
  end

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    @(negedge clk); busRd = 1'b0;
    check("R8 read data", int'(busRdData), 0);
  endtask

  task automatic waitPulses(input int k);
    int n0 = pulseAt.size();
    while (pulseAt.size() < n0 + k) @(posedge clk);
  endtask

  function automatic int lastGap(input int back);
    return pulseAt[pulseAt.size()-1-back] - pulseAt[pulseAt.size()-2-back];
  endfunction

  initial begin
    #(20ns * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pulse low in reset", int'(divPulse), 0);
    rst = 1'b0;
    waitPulses(3);
    check("R1 reset period", lastGap(0), 2);

    wr(8'h5C, 8'h05);
    waitPulses(3);
    check("R3 low byte alone", lastGap(0), 2);

    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R4 commit N=5", lastGap(0), 5);

    // R5: commit mid-count
    waitPulses(1);
    wr(8'h5C, 8'h09);
    wr(8'h5D, 8'h00);
    waitPulses(2);
    check("R5 old period completes", lastGap(1), 5);
    check("R5 new period", lastGap(0), 9);

    wr(8'h5C, 8'h03);
    wr(8'h5D, 8'hF9);
    waitPulses(3);
    check("R4 upper bits ignored N=259", lastGap(0), 259);

    wr(8'h5C, 8'h00);
    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R6 N=0 acts as 2", lastGap(0), 2);
    wr(8'h5C, 8'h01);
    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R6 N=1 acts as 2", lastGap(0), 2);

    wr(8'h5C, 8'h06);
    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R4 N=6", lastGap(0), 6);

    @(negedge clk); pllEnable = 1'b1;
    wr(8'h5C, 8'h0A);
    wr(8'h5D, 8'h00);
    @(negedge clk); pllEnable = 1'b0;
    waitPulses(3);
    check("R7 active unchanged", lastGap(0), 6);
    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R7 staging unchanged", lastGap(0), 6);

    wr(8'h5E, 8'h01);
    wr(8'h5B, 8'h03);
    wr(8'h5D, 8'h00);
    waitPulses(3);
    check("R9 other addresses ignored", lastGap(0), 6);

    rd(8'h5C);
    rd(8'h5D);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule